// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a regular interrupt for an operating-system tick or any software that needs a fixed time base. A programmable prescaler divides the selected count source. Each prescaler tick moves a down-counter one step toward zero. When the counter lands on zero, a sticky event flag is set, and the interrupt line is raised if software has unmasked it. On the following tick the counter takes the programmed reload value again, so the countdown repeats without software help.

Software drives the block through a small synchronous register bus with word addresses. It chooses the count source: either every system clock cycle, or a second timer clock that is modelled here as a one-cycle enable input sampled on the system clock. It can also stop and resume counting, program the division ratio and the reload value, read the running count, and acknowledge the event by writing a one to the flag.

Writing a new reload value abandons the countdown in progress. The same write clears the prescaler and starts counting from the new value, which makes the distance to the next interrupt exact.

Top module: `pit_timer`

## Requirements
- R1: After reset every register reads zero, counting is stopped, the interrupt is masked and `irq_o` is low.
- R2: The prescaler gives one tick every (prescale + 1) cycles of the selected source. When control bit 2 is 0 the source is every clock cycle. When it is 1 the source is the cycles in which `alt_tick` is high, and with `alt_tick` low the count does not move.
- R3: Each tick decrements the counter. With a reload value L of 1 or more and prescale P, the first zero event comes L*(P+1) cycles after counting starts. Later events repeat every (L+1)*(P+1) cycles. A zero event sets the flag.
- R4: On the tick after the counter reaches zero, the counter takes the reload value. A reload value of 0 therefore gives an event on every tick, the first one P+1 cycles after the start.
- R5: A write to the reload register puts the written value in the counter on the next cycle and restarts the prescaler from zero, whatever the counter was doing.
- R6: While control bit 0 (enable) is 0, neither the counter nor the prescaler changes, except through a reload write.
- R7: The event flag is bit 0 of the event register. Writing 1 to it clears the flag, and writing 0 has no effect. If a zero event and a clearing write fall in the same cycle, the flag stays set.
- R8: `irq_o` is high exactly when the flag is set and control bit 1 (mask enable) is 1. Masking hides the interrupt, but the flag stays set.
- R9: Word addresses: 0 control (bit 0 enable, bit 1 mask enable, bit 2 source select), 1 reload, 2 prescale, 3 count (read only; writes are ignored), 4 event. Unused event bits and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_tick | input | 1 | Count enable from the alternate timer clock, one cycle wide |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, zero when `bus_sel` is low |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that a bus write lasts exactly one cycle. They also assume that `alt_tick` is a clean synchronous enable, so that a reload write and a tick in the same cycle resolve in favour of the write. The stimulus drives every bus access as a single-cycle strobe on the falling clock edge. Random reload and prescale values are kept small, so that whole periods fit in the run. The alternate source is driven with random per-cycle pulses, and the bench counts those pulses itself to build its expected values.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
   localparam logic [ADDR_W-1:0] A_PRSC  = 3'd2;
   localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
   localparam logic [ADDR_W-1:0] A_EVENT = 3'd4;

   // control register: bit0 enable, bit1 mask enable, bit2 source select
   typedef struct packed {
      logic src_alt;
      logic mask;
      logic en;
   } ctrl_t;
   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int unsigned PRE_W   = 32,
   parameter bit          ALT_SRC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             src_alt,
   input  logic             alt_tick,
   input  logic             restart,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] pcnt;
   logic src, step, wrap;

   generate
      if (ALT_SRC) begin : g_sel
         assign src = src_alt ? alt_tick : 1'b1;
      end else begin : g_sys
         logic unused_alt;
         assign unused_alt = src_alt ^ alt_tick;
         assign src = 1'b1;
      end
   endgenerate

   assign step = en & src & ~restart;
   assign wrap = (pcnt >= limit);
   assign tick = step & wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (step)    pcnt <= wrap ? '0 : pcnt + 1'b1;
   end

   assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0));
   assert_prescaler_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> $stable(pcnt));
   assert_tick_only_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pcnt == '0));
endmodule

// File: rtl/pit_downcounter.sv
module pit_downcounter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt
);
   logic [CNT_W-1:0] nxt;

   assign nxt      = (count == '0) ? reload_val : count - 1'b1;
   assign zero_evt = tick & ~ld & (nxt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (ld)   count <= ld_val;
      else if (tick) count <= nxt;
   end

   assert_load_takes_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (count == $past(ld_val)));
   assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(count));
   assert_reload_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && count == '0) |=> (count == $past(reload_val)));
   assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && count != '0) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PRE_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              zero_evt,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  load_val,
   output logic [PRE_W-1:0]  pre_val,
   output logic              ld_pulse,
   output logic              flag
);
   logic wr, clr_req;

   assign wr       = bus_sel & bus_we;
   assign ld_pulse = wr && (bus_addr == A_LOAD);
   assign clr_req  = wr && (bus_addr == A_EVENT) && bus_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         load_val <= '0;
         pre_val  <= '0;
      end else if (wr) begin
         case (bus_addr)
            A_CTRL:  ctrl     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            A_LOAD:  load_val <= bus_wdata[CNT_W-1:0];
            A_PRSC:  pre_val  <= bus_wdata[PRE_W-1:0];
            default: ;
         endcase
      end
   end

   // a zero event takes priority over a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n)        flag <= 1'b0;
      else if (zero_evt) flag <= 1'b1;
      else if (clr_req)  flag <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl;
            A_LOAD:  bus_rdata[CNT_W-1:0]  = load_val;
            A_PRSC:  bus_rdata[PRE_W-1:0]  = pre_val;
            A_COUNT: bus_rdata[CNT_W-1:0]  = count;
            A_EVENT: bus_rdata[0]          = flag;
            default: bus_rdata             = '0;
         endcase
      end
   end

   assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> flag);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);
   assert_flag_rises_on_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(zero_evt));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned PRE_W   = 32,
   parameter bit          ALT_SRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt_tick,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("pit_timer: CNT_W must be 1..DATA_W");
      end
      if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
         $error("pit_timer: PRE_W must be 1..DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("pit_timer: DATA_W too narrow for control");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] load_val, count;
   logic [PRE_W-1:0] pre_val;
   logic             ld_pulse, flag, tick, zero_evt;

   pit_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .count, .zero_evt, .ctrl, .load_val, .pre_val, .ld_pulse, .flag
   );

   pit_prescaler #(.PRE_W(PRE_W), .ALT_SRC(ALT_SRC)) u_pre (
      .clk, .rst_n, .en(ctrl.en), .src_alt(ctrl.src_alt), .alt_tick,
      .restart(ld_pulse), .limit(pre_val), .tick
   );

   pit_downcounter #(.CNT_W(CNT_W)) u_cnt (
      .clk, .rst_n, .tick, .ld(ld_pulse), .ld_val(bus_wdata[CNT_W-1:0]),
      .reload_val(load_val), .count, .zero_evt
   );

   assign irq_o = flag & ctrl.mask;

   assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ctrl.mask);
   assert_no_tick_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> !tick);
endmodule

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alt_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int unsigned checks = 0, fails = 0;
   int unsigned cyc = 0;
   bit done = 0;

   pit_timer uut (.clk, .rst_n, .alt_tick, .bus_sel, .bus_we, .bus_addr,
                  .bus_wdata, .bus_rdata, .irq_o);

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int unsigned first_delay(int unsigned l, int unsigned p);
      return ((l == 0) ? 1 : l) * (p + 1);
   endfunction
   function automatic int unsigned period_len(int unsigned l, int unsigned p);
      return (l + 1) * (p + 1);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic wait_irq(output int unsigned t);
      int unsigned lim = 0;
      while (!irq_o && lim < 5000) begin
         @(negedge clk); lim++;
      end
      t = cyc;
   endtask

   task automatic setup(int unsigned l, int unsigned p, logic [31:0] ctl,
                        output int unsigned t0);
      wr(3'd0, 32'd0);
      wr(3'd4, 32'd1);
      wr(3'd2, p);
      wr(3'd1, l);
      wr(3'd0, ctl);
      t0 = cyc;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] v, v2;
      int unsigned t0, t1, t2, n;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state, R9 map
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v); chk("R1 reset read", v, 0);
      end
      chk("R1 irq after reset", irq_o, 0);
      wr(3'd3, 32'h1234);
      rd(3'd3, v); chk("R9 count write ignored", v, 0);
      wr(3'd2, 32'd5); rd(3'd2, v); chk("R9 prescale readback", v, 5);
      wr(3'd0, 32'd7); rd(3'd0, v); chk("R9 control readback", v, 7);
      rd(3'd6, v); chk("R9 unmapped reads zero", v, 0);

      // R3/R4 directed plus random periods
      for (int i = 0; i < 8; i++) begin
         int unsigned l = (i == 0) ? 3 : 1 + $urandom % 8;
         int unsigned p = (i == 0) ? 2 : $urandom % 6;
         setup(l, p, 32'h3, t0);
         wait_irq(t1);
         chk("R3 first event delay", t1 - t0, first_delay(l, p));
         rd(3'd3, v); chk("R3 count zero at event", v, 0);
         wr(3'd4, 32'd1);
         chk("R7 flag cleared by one", irq_o, 0);
         wait_irq(t2);
         chk("R4 reload period", t2 - t1, period_len(l, p));
      end

      // R4 zero reload value
      setup(0, 3, 32'h3, t0);
      wait_irq(t1);
      chk("R4 zero reload first event", t1 - t0, first_delay(0, 3));
      wr(3'd4, 32'd1);
      wait_irq(t2);
      chk("R4 zero reload period", t2 - t1, 4);

      // R7 set wins over simultaneous clear
      setup(1, 0, 32'h3, t0);
      wr(3'd4, 32'd1);
      rd(3'd4, v); chk("R7 set wins over clear", v, 1);
      wr(3'd4, 32'd1);
      rd(3'd4, v); chk("R7 clear without event", v, 0);

      // R6 freeze while disabled
      setup(50, 1, 32'h3, t0);
      repeat (10) @(negedge clk);
      wr(3'd0, 32'h2);
      rd(3'd3, v);
      repeat (12) @(negedge clk);
      rd(3'd3, v2); chk("R6 count frozen", v2, v);
      chk("R6 count moved before disable", v, 45);

      // R5 restart on reload write
      wr(3'd0, 32'h3);
      repeat (5) @(negedge clk);
      wr(3'd1, 32'd7);
      t0 = cyc;
      rd(3'd3, v); chk("R5 count takes new value", v, 7);
      wait_irq(t1);
      chk("R5 restart delay", t1 - t0, 14);

      // R2 alternate source
      setup(2, 1, 32'h7, t0);
      n = 0;
      for (int k = 0; k < 200; k++) begin
         if (irq_o) break;
         alt_tick = 1'($urandom % 2);
         if (alt_tick) n++;
         @(negedge clk);
      end
      alt_tick = 0;
      chk("R2 alternate pulses to event", n, 4);
      rd(3'd3, v);
      repeat (8) @(negedge clk);
      rd(3'd3, v2); chk("R2 no pulses no count", v2, v);

      // R8 masking
      setup(2, 0, 32'h1, t0);
      repeat (5) @(negedge clk);
      chk("R8 masked irq low", irq_o, 0);
      rd(3'd4, v); chk("R8 flag kept while masked", v, 1);
      wr(3'd0, 32'h2);
      chk("R8 unmask raises irq", irq_o, 1);
      wr(3'd4, 32'd0);
      rd(3'd4, v); chk("R7 write zero no effect", v, 1);
      wr(3'd4, 32'hFFFF_FFFE);
      rd(3'd4, v); chk("R9 event upper bits zero", v, 1);

      summary();
   end
endmodule